// File: doc/BRIEF.md
# ROM Overlay Paging Controller

This block sits beside an 8-bit host processor's memory and I/O bus and decides when the host's built-in ROM must leave the bus so that an add-on interface can map its own ROM and RAM into the lowest 16 KB of memory. A memory read from one of a few fixed trap addresses pages the overlay in. So does holding the host reset line, or an I/O write to the paging port. The paged state then holds itself until an I/O access to the paging port releases it.

A two-state boot latch decides how the 16 KB overlay window is split. In the normal state, ROM fills the lower 8 KB and RAM the upper 8 KB. In the swapped state, the two halves trade places. The latch returns to the normal state on reset or on an I/O read of the boot port. An I/O write of the boot port moves it to the swapped state.

All outputs are combinational from the current bus cycle and a small amount of registered state. I/O port actions act on the first clock of a strobe, so each bus access acts once however long it lasts.

Top module: `rom_overlay_pager`

## Requirements
- R1: While `rst_n` is low, `romcs_o` is 1. Reset clears the paged state and puts the boot latch in the normal state, so once `rst_n` is high and the bus is idle, `romcs_o` is 0 and both chip enables are 1.
- R2: A memory read (`mreq_n`=0, `rd_n`=0) at address 0x0000, 0x0001, 0x0008, 0x0066 or 0x028E drives `romcs_o` to 1 in that same cycle. The paged state holds from the next clock on. A read at any other address, such as 0x0002 or 0x0067, leaves `romcs_o` at 0.
- R3: While not paged, an I/O write (`iorq_n`=0, `wr_n`=0) whose low address byte is 0xBB pages the overlay in from the next clock on. An I/O read of 0xBB while not paged does nothing.
- R4: While paged, an I/O read or write of port 0xBB releases paging from the next clock on. Each I/O strobe acts once, however many clocks it is held.
- R5: While paged, any access other than a port 0xBB access leaves `romcs_o` at 1. This includes memory accesses anywhere and I/O to other ports.
- R6: The boot latch enters the swapped state on an I/O write whose low address byte is 0x7B. It returns to the normal state on an I/O read of 0x7B, or on reset. Boot-port accesses do not change the paged state.
- R7: In the normal state, `rom_ce_n` is 0 for memory reads in 0x0000–0x1FFF. `ram_ce_n` is 0 for memory reads and writes in 0x2000–0x3FFF.
- R8: In the swapped state, `rom_ce_n` is 0 for memory reads in 0x2000–0x3FFF. `ram_ce_n` is 0 for memory reads and writes in 0x0000–0x1FFF.
- R9: A chip enable is 0 only when `romcs_o` is 1, `mreq_n` is 0, and address bits 15 and 14 are both 0. The two enables are never 0 together, and `rom_ce_n` is never 0 during a write.
- R10: A memory write to a trap address does not page the overlay in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-synchronous clock |
| rst_n | input | 1 | Host reset line, active low |
| addr | input | 16 | Address bus; the low byte selects the I/O port |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| romcs_o | output | 1 | Host ROM disable, active high |
| rom_ce_n | output | 1 | Overlay ROM chip enable, active low |
| ram_ce_n | output | 1 | Overlay RAM chip enable, active low |

## Verification
The assertions assume well-formed bus cycles:
- `mreq_n` and `iorq_n` are never low together.
- `rd_n` and `wr_n` are never low together.
- Inputs change only between clock edges.

The bench drives every bus cycle from tasks that move the strobes at the falling edge. Each task sets exactly one request and one direction and returns the bus to idle before the next cycle. Because of this, the event-to-state implications checked by the assertions (trap to paged, port access to release, boot writes and reads to latch state) are never muddied by conflicting strobes.

// File: rtl/rop_pkg.sv
package rop_pkg;
  localparam int ADDR_W = 16;
  localparam int PORT_W = 8;

  typedef enum logic {BOOT_NORMAL = 1'b0, BOOT_SWAPPED = 1'b1} boot_e;

  function automatic logic is_trap(input logic [ADDR_W-1:0] a);
    return (a == 16'h0000) || (a == 16'h0001) || (a == 16'h0008) ||
           (a == 16'h0066) || (a == 16'h028E);
  endfunction

  function automatic logic port_hit(input logic [ADDR_W-1:0] a,
                                    input logic [PORT_W-1:0] port);
    return a[PORT_W-1:0] == port;
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-2] == 2'b00;
  endfunction

  // 1 when the address lies in the half that holds ROM for the given state
  function automatic logic rom_half(input logic [ADDR_W-1:0] a, input boot_e st);
    return (st == BOOT_SWAPPED) ? a[ADDR_W-3] : !a[ADDR_W-3];
  endfunction
endpackage

// File: rtl/rop_strobe_start.sv
module rop_strobe_start (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic start
);
  logic level_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end
  assign start = level && !level_q;
endmodule

// File: rtl/rop_boot_latch.sv
module rop_boot_latch
  import rop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  to_normal,
  input  logic  to_swapped,
  output boot_e state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          state <= BOOT_NORMAL;
    else if (to_normal)  state <= BOOT_NORMAL;
    else if (to_swapped) state <= BOOT_SWAPPED;
  end
endmodule

// File: rtl/rop_ce_decode.sv
module rop_ce_decode
  import rop_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              romcs,
  input  boot_e             boot_st,
  output logic              rom_ce_n,
  output logic              ram_ce_n
);
  logic mem_ok;
  assign mem_ok   = romcs && !mreq_n && in_window(addr);
  assign rom_ce_n = !(mem_ok && !rd_n && rom_half(addr, boot_st));
  assign ram_ce_n = !(mem_ok && (!rd_n || !wr_n) && !rom_half(addr, boot_st));
endmodule

// File: rtl/rom_overlay_pager.sv
module rom_overlay_pager
  import rop_pkg::*;
#(
  parameter logic [PORT_W-1:0] PAGE_PORT = 8'hBB,
  parameter logic [PORT_W-1:0] BOOT_PORT = 8'h7B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              romcs_o,
  output logic              rom_ce_n,
  output logic              ram_ce_n
);
  localparam int N_STROBE = 2; // index 0: I/O read, 1: I/O write

  logic [N_STROBE-1:0] io_lvl, io_start;
  assign io_lvl[0] = !iorq_n && !rd_n;
  assign io_lvl[1] = !iorq_n && !wr_n;

  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    rop_strobe_start u_start (
      .clk(clk), .rst_n(rst_n), .level(io_lvl[g]), .start(io_start[g])
    );
  end

  // Named events for the checker
  logic trap_hit, page_rd_ev, page_wr_ev, page_ev, boot_rd_ev, boot_wr_ev;
  logic paged_q;
  boot_e boot_st;

  assign trap_hit   = !mreq_n && !rd_n && is_trap(addr);
  assign page_rd_ev = io_start[0] && port_hit(addr, PAGE_PORT);
  assign page_wr_ev = io_start[1] && port_hit(addr, PAGE_PORT);
  assign page_ev    = page_rd_ev || page_wr_ev;
  assign boot_rd_ev = io_start[0] && port_hit(addr, BOOT_PORT);
  assign boot_wr_ev = io_start[1] && port_hit(addr, BOOT_PORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    paged_q <= 1'b0;
    else if (trap_hit)             paged_q <= 1'b1;
    else if (paged_q && page_ev)   paged_q <= 1'b0;
    else if (page_wr_ev)           paged_q <= 1'b1;
  end

  rop_boot_latch u_boot (
    .clk(clk), .rst_n(rst_n), .to_normal(boot_rd_ev),
    .to_swapped(boot_wr_ev), .state(boot_st)
  );

  assign romcs_o = !rst_n || paged_q || trap_hit;

  rop_ce_decode u_ce (
    .addr(addr), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .romcs(romcs_o), .boot_st(boot_st),
    .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n)
  );
endmodule

// File: rtl/rom_overlay_pager_chk.sv
module rom_overlay_pager_chk
  import rop_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              mreq_n,
  input logic              wr_n,
  input logic              romcs_o,
  input logic              rom_ce_n,
  input logic              ram_ce_n,
  input logic              trap_hit,
  input logic              page_ev,
  input logic              boot_rd_ev,
  input logic              boot_wr_ev,
  input logic              paged_q,
  input boot_e             boot_st
);
  a_r1_reset_disables_rom: assert property (@(posedge clk) !rst_n |-> romcs_o);
  a_r2_trap_pages: assert property (@(posedge clk) disable iff (!rst_n)
    trap_hit |=> paged_q);
  a_r4_port_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (paged_q && page_ev && !trap_hit) |=> !paged_q);
  a_r5_paged_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (paged_q && !page_ev) |=> paged_q);
  a_r6_boot_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    boot_wr_ev |=> (boot_st == BOOT_SWAPPED));
  a_r6_boot_restores: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rd_ev |=> (boot_st == BOOT_NORMAL));
  a_r9_ce_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_ce_n || !ram_ce_n) |-> (romcs_o && !mreq_n && addr[15:14] == 2'b00));
  a_r9_ce_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_ce_n && !ram_ce_n));
  a_r9_rom_not_written: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_ce_n |-> wr_n);
endmodule

bind rom_overlay_pager rom_overlay_pager_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .wr_n(wr_n),
  .romcs_o(romcs_o), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n),
  .trap_hit(trap_hit), .page_ev(page_ev), .boot_rd_ev(boot_rd_ev),
  .boot_wr_ev(boot_wr_ev), .paged_q(paged_q), .boot_st(boot_st)
);

// File: tb/rom_overlay_pager_tb_top.sv
`timescale 1ns/1ps
module rom_overlay_pager_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] addr = 16'h0;
  logic mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic romcs_o, rom_ce_n, ram_ce_n;

  int checks = 0;
  int failures = 0;
  bit m_paged = 1'b0;   // bench model of paging
  bit m_swap  = 1'b0;   // bench model of boot latch

  always #2.5 clk = ~clk;

  rom_overlay_pager dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
    .rd_n(rd_n), .wr_n(wr_n), .romcs_o(romcs_o), .rom_ce_n(rom_ce_n),
    .ram_ce_n(ram_ce_n)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic exp_rom_n(input logic [15:0] a, input bit rd, input bit on, input bit sw);
    bit lo_half = (a[13] == 1'b0);
    return !(on && a[15:14] == 2'b00 && rd && (sw ? !lo_half : lo_half));
  endfunction
  function automatic logic exp_ram_n(input logic [15:0] a, input bit on, input bit sw);
    bit lo_half = (a[13] == 1'b0);
    return !(on && a[15:14] == 2'b00 && (sw ? lo_half : !lo_half));
  endfunction

  task automatic bus_idle();
    @(negedge clk);
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  // One memory cycle; checks ROMCS and enables while the strobe is low.
  task automatic mem(input string req, input logic [15:0] a, input bit wr, input bit exp_cs);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = wr; wr_n = !wr;
    #1;
    chk(req, romcs_o, exp_cs);
    chk(req, rom_ce_n, exp_rom_n(a, !wr, exp_cs, m_swap));
    chk(req, ram_ce_n, exp_ram_n(a, exp_cs, m_swap));
    bus_idle();
  endtask

  task automatic io(input logic [7:0] port, input bit wr, input int hold);
    @(negedge clk);
    addr = {8'h12, port}; iorq_n = 1'b0; rd_n = wr; wr_n = !wr;
    for (int i = 0; i < hold; i++) @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 romcs in reset", romcs_o, 1'b1);
    @(negedge clk); rst_n = 1'b1; #1;
    m_paged = 0; m_swap = 0;
    chk("R1 romcs after reset", romcs_o, 1'b0);
    chk("R1 rom_ce idle", rom_ce_n, 1'b1);
    chk("R1 ram_ce idle", ram_ce_n, 1'b1);
  endtask

  task automatic t_traps();
    logic [15:0] traps [5] = '{16'h0000, 16'h0001, 16'h0008, 16'h0066, 16'h028E};
    foreach (traps[i]) begin
      mem("R2 trap read", traps[i], 1'b0, 1'b1);
      chk("R2 trap holds", romcs_o, 1'b1);
      io(8'hBB, 1'b1, 1);
      chk("R4 release after trap", romcs_o, 1'b0);
    end
    mem("R2 non-trap 0002", 16'h0002, 1'b0, 1'b0);
    mem("R2 non-trap 0067", 16'h0067, 1'b0, 1'b0);
    mem("R10 write to trap", 16'h0066, 1'b1, 1'b0);
    chk("R10 no paging after write", romcs_o, 1'b0);
  endtask

  task automatic t_port();
    io(8'hBB, 1'b0, 1);
    chk("R3 read of page port unpaged", romcs_o, 1'b0);
    io(8'hBB, 1'b1, 3);
    chk("R3 page-in by write held 3", romcs_o, 1'b1);
    io(8'h1F, 1'b1, 1);
    chk("R5 other port keeps paged", romcs_o, 1'b1);
    mem("R5 high memory keeps paged", 16'h8000, 1'b0, 1'b1);
    io(8'hBB, 1'b0, 4);
    chk("R4 release by read held 4", romcs_o, 1'b0);
  endtask

  task automatic t_latch();
    io(8'hBB, 1'b1, 1); m_paged = 1;
    mem("R7 rom read lo", 16'h0100, 1'b0, 1'b1);
    mem("R7 ram read hi", 16'h2100, 1'b0, 1'b1);
    mem("R7 write lo no ce", 16'h0100, 1'b1, 1'b1);
    mem("R7 ram write hi", 16'h3FFF, 1'b1, 1'b1);
    io(8'h7B, 1'b1, 2); m_swap = 1;
    chk("R6 boot write keeps paged", romcs_o, 1'b1);
    mem("R8 rom read hi", 16'h2100, 1'b0, 1'b1);
    mem("R8 ram read lo", 16'h0100, 1'b0, 1'b1);
    mem("R8 ram write lo", 16'h1FFF, 1'b1, 1'b1);
    mem("R8 write hi no ce", 16'h2100, 1'b1, 1'b1);
    io(8'h7B, 1'b0, 1); m_swap = 0;
    mem("R6 back to normal", 16'h0100, 1'b0, 1'b1);
    io(8'h7B, 1'b1, 1); m_swap = 1;
    mem("R6 swapped again", 16'h0100, 1'b0, 1'b1);
    do_reset();
    io(8'hBB, 1'b1, 1); m_paged = 1;
    mem("R6 reset restores normal", 16'h0100, 1'b0, 1'b1);
  endtask

  task automatic t_window();
    logic [15:0] outs [4] = '{16'h4000, 16'h7FFF, 16'h8000, 16'hC123};
    foreach (outs[i]) begin
      mem("R9 outside window read", outs[i], 1'b0, 1'b1);
      mem("R9 outside window write", outs[i], 1'b1, 1'b1);
    end
    @(negedge clk);
    addr = 16'h0100; iorq_n = 1'b0; rd_n = 1'b0; #1;
    chk("R9 io read no rom ce", rom_ce_n, 1'b1);
    chk("R9 io read no ram ce", ram_ce_n, 1'b1);
    bus_idle();
    io(8'hBB, 1'b1, 1); m_paged = 0;
    mem("R9 unpaged no ce", 16'h0100, 1'b0, 1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 romcs held in reset", romcs_o, 1'b1);
    do_reset();
    t_traps();
    t_port();
    t_latch();
    t_window();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule